// File: doc/BRIEF.md
# 64-bit Split-Access Timebase

The block keeps a 64-bit count of elapsed events since reset and puts it on a 32-bit register bus. Software sees the count as two 32-bit halves. Each half-access protocol keeps the two halves consistent.

A write to the low write port only fills a staging word. A later write to the high write port loads the high data and the staged low word into the counter together. A read of the low read port captures the high half at that same instant. A later read of the high read port returns the captured word. Two raw read ports return live counter bits and leave the capture register alone.

Counting can be stopped in two ways: by a software pause bit, or by a per-input enable on a debug-active vector. A source selector chooses the count event: an external tick-enable, or every clock cycle. A write-once lock freezes every register against later writes until reset. The full count is also driven on a 64-bit output for other logic.

Top module: `timebase_split`

## Requirements
- R1: After reset the count is zero, and the pause, source select, debug enables and lock all read 0. A read of the high read port (0x08) returns 0 before any low read.
- R2: With source select (offset 0x38, bit 0) at 1, the count increases by exactly one on every clock cycle while not stopped.
- R3: With source select at 0, the count increases by one only on cycles where `tick_en` is high.
- R4: A write to offset 0x04 leaves the count unchanged and stores a staging word. A write to offset 0x00 loads the count with {write data, staging word}. The new value is visible on `time_o` after that clock edge.
- R5: A load from an offset 0x00 write wins over an increment in the same cycle. The next counting cycle then yields the loaded value plus one.
- R6: A read of offset 0x0C returns the live low 32 bits and captures the live high 32 bits. A later read of offset 0x08 returns that captured word, even after the live high half has moved on.
- R7: Reads of offset 0x24 (high) and 0x28 (low) return live count bits. They do not change what offset 0x08 returns.
- R8: While pause (offset 0x30, bit 0) is 1, the count holds its value.
- R9: Debug enables sit at offset 0x2C, bit i for `dbg_act[i]`, i = 0..1. The count holds whenever `dbg_act[i]` and enable bit i are both 1 for some i. Otherwise it counts as usual.
- R10: Writing 1 to bit 0 of offset 0x34 sets the lock. Writing 0 to that bit while unlocked has no effect. Once the lock is set, every register write is ignored, including writes to offsets 0x00, 0x04, 0x30, 0x38 and 0x34. Only reset clears the lock.
- R11: Read data appears on `bus_rdata` one cycle after the read strobe. Offsets 0x2C, 0x30, 0x34 and 0x38 read back their bits, zero-extended. Unmapped offsets, and the write-only offsets 0x00 and 0x04, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the strobe |
| tick_en | input | 1 | External count event for source select 0 |
| dbg_act | input | 2 | Debug-active inputs |
| time_o | output | 64 | Live count |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together, and that every input changes only between clock edges. The stimulus drives all inputs at the falling edge and runs each access as a single-cycle strobe. Each expected count comes from the number of qualifying edges the bench itself has counted. That count is taken over a window bounded by falling-edge samples of `time_o`. The debug gating is swept over every enable and activity combination. The tick gating is swept over several duty patterns.

// File: rtl/timebase_split_pkg.sv
package timebase_split_pkg;

  localparam int unsigned OFS_HI_WR  = 'h00;
  localparam int unsigned OFS_LO_WR  = 'h04;
  localparam int unsigned OFS_HI_RD  = 'h08;
  localparam int unsigned OFS_LO_RD  = 'h0C;
  localparam int unsigned OFS_RAW_HI = 'h24;
  localparam int unsigned OFS_RAW_LO = 'h28;
  localparam int unsigned OFS_DBG_EN = 'h2C;
  localparam int unsigned OFS_PAUSE  = 'h30;
  localparam int unsigned OFS_LOCK   = 'h34;
  localparam int unsigned OFS_SRC    = 'h38;

  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_CLK  = 1'b1
  } src_sel_e;

endpackage

// File: rtl/timebase_split_regs.sv
module timebase_split_regs
  import timebase_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned DBG_N  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [HALF_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  output logic                  load_o,
  output logic [2*HALF_W-1:0]   load_val_o,
  output logic                  pause_o,
  output src_sel_e              src_o,
  output logic                  lock_o,
  output logic [DBG_N-1:0]      dbg_en_o
);

  logic              wr_ok;
  logic [HALF_W-1:0] stage_q;
  logic              pause_q;
  src_sel_e          src_q;
  logic              lock_q;
  logic [DBG_N-1:0]  dbg_en_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_ok = bus_wr & ~lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      pause_q  <= 1'b0;
      src_q    <= SRC_TICK;
      lock_q   <= 1'b0;
      dbg_en_q <= '0;
    end else if (wr_ok) begin
      if (hit(bus_addr, OFS_LO_WR))  stage_q  <= bus_wdata;
      if (hit(bus_addr, OFS_PAUSE))  pause_q  <= bus_wdata[0];
      if (hit(bus_addr, OFS_SRC))    src_q    <= src_sel_e'(bus_wdata[0]);
      if (hit(bus_addr, OFS_LOCK))   lock_q   <= bus_wdata[0];
      if (hit(bus_addr, OFS_DBG_EN)) dbg_en_q <= bus_wdata[DBG_N-1:0];
    end
  end

  assign load_o     = wr_ok & hit(bus_addr, OFS_HI_WR);
  assign load_val_o = {bus_wdata, stage_q};
  assign pause_o    = pause_q;
  assign src_o      = src_q;
  assign lock_o     = lock_q;
  assign dbg_en_o   = dbg_en_q;

  // R10: lock is sticky
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R10: locked registers never change
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(pause_q) && $stable(src_q) && $stable(dbg_en_q) && $stable(stage_q)));

  // R4: staging word only moves on a low-write
  a_r4_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit(bus_addr, OFS_LO_WR)) |=> $stable(stage_q));

endmodule

// File: rtl/timebase_split_count.sv
module timebase_split_count
  import timebase_split_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DBG_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  src_sel_e          src_sel,
  input  logic              pause,
  input  logic [DBG_N-1:0]  dbg_act,
  input  logic [DBG_N-1:0]  dbg_en,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  count_o,
  output logic              advance_o
);

  logic [CNT_W-1:0] count_q;
  logic             halted;
  logic             event_sel;

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic ld,
    input logic [CNT_W-1:0] ldv, input logic adv);
    if (ld)       return ldv;
    else if (adv) return cur + CNT_W'(1);
    else          return cur;
  endfunction

  assign halted    = pause | (|(dbg_act & dbg_en));
  assign event_sel = (src_sel == SRC_CLK) ? 1'b1 : tick_en;
  assign advance_o = event_sel & ~halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= next_count(count_q, load, load_val, advance_o);
  end

  assign count_o = count_q;

  // R2: one step per qualifying event
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance_o) |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R4 / R5: load wins
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));

  // R3: no tick, no step in tick mode
  a_r3_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && src_sel == SRC_TICK && !tick_en) |=> $stable(count_q));

  // R8: pause holds
  a_r8_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pause) |=> $stable(count_q));

  // R9: enabled debug activity holds
  a_r9_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (|(dbg_act & dbg_en))) |=> $stable(count_q));

endmodule

// File: rtl/timebase_split_rdport.sv
module timebase_split_rdport
  import timebase_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned DBG_N  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic [2*HALF_W-1:0]  count,
  input  logic                 pause,
  input  src_sel_e             src_sel,
  input  logic                 lock,
  input  logic [DBG_N-1:0]     dbg_en,
  output logic [HALF_W-1:0]    rdata_o
);

  logic [HALF_W-1:0] hi_latch_q;
  logic [HALF_W-1:0] rdata_q;
  logic [HALF_W-1:0] rd_mux;
  logic              capture;
  logic [HALF_W-1:0] live_hi;
  logic [HALF_W-1:0] live_lo;

  function automatic logic [HALF_W-1:0] bit_field(input logic b);
    return {{(HALF_W-1){1'b0}}, b};
  endfunction

  assign live_hi = count[2*HALF_W-1:HALF_W];
  assign live_lo = count[HALF_W-1:0];
  assign capture = bus_rd & (bus_addr == ADDR_W'(OFS_LO_RD));

  always_comb begin
    rd_mux = '0;
    if      (bus_addr == ADDR_W'(OFS_LO_RD))  rd_mux = live_lo;
    else if (bus_addr == ADDR_W'(OFS_HI_RD))  rd_mux = hi_latch_q;
    else if (bus_addr == ADDR_W'(OFS_RAW_HI)) rd_mux = live_hi;
    else if (bus_addr == ADDR_W'(OFS_RAW_LO)) rd_mux = live_lo;
    else if (bus_addr == ADDR_W'(OFS_PAUSE))  rd_mux = bit_field(pause);
    else if (bus_addr == ADDR_W'(OFS_SRC))    rd_mux = bit_field(src_sel == SRC_CLK);
    else if (bus_addr == ADDR_W'(OFS_LOCK))   rd_mux = bit_field(lock);
    else if (bus_addr == ADDR_W'(OFS_DBG_EN)) rd_mux = {{(HALF_W-DBG_N){1'b0}}, dbg_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_latch_q <= '0;
      rdata_q    <= '0;
    end else begin
      if (capture) hi_latch_q <= live_hi;
      rdata_q <= bus_rd ? rd_mux : '0;
    end
  end

  assign rdata_o = rdata_q;

  // R6: capture takes the high half of the same instant
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (hi_latch_q == $past(live_hi)));

  // R7: latch untouched by any other access
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(hi_latch_q));

endmodule

// File: rtl/timebase_split.sv
module timebase_split
  import timebase_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned DBG_N  = 2,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [HALF_W-1:0] bus_rdata,
  input  logic              tick_en,
  input  logic [DBG_N-1:0]  dbg_act,
  output logic [CNT_W-1:0]  time_o
);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             pause;
  src_sel_e         src_sel;
  logic             lock;
  logic [DBG_N-1:0] dbg_en;
  logic [CNT_W-1:0] count;
  logic             advance;

  timebase_split_regs #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .DBG_N(DBG_N)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .load_o(load), .load_val_o(load_val), .pause_o(pause),
    .src_o(src_sel), .lock_o(lock), .dbg_en_o(dbg_en)
  );

  timebase_split_count #(.CNT_W(CNT_W), .DBG_N(DBG_N)) count_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .src_sel(src_sel),
    .pause(pause), .dbg_act(dbg_act), .dbg_en(dbg_en), .load(load),
    .load_val(load_val), .count_o(count), .advance_o(advance)
  );

  timebase_split_rdport #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .DBG_N(DBG_N)) rd_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .count(count), .pause(pause), .src_sel(src_sel), .lock(lock),
    .dbg_en(dbg_en), .rdata_o(bus_rdata)
  );

  assign time_o = count;

  // R1: zero count right after reset
  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> (count == '0));

  // R10: a locked block never loads
  a_r10_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !advance) |=> $stable(count));

endmodule

// File: tb/timebase_split_tb_top.sv
module timebase_split_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic [1:0]  dbg_act = '0;
  logic [63:0] time_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  timebase_split dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .dbg_act(dbg_act), .time_o(time_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] a0;
    int highs;

    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 time", time_o, 64'd0);
    rd(8'h30, d); chk("R1 pause", {32'd0, d}, 64'd0);
    rd(8'h38, d); chk("R1 source", {32'd0, d}, 64'd0);
    rd(8'h34, d); chk("R1 lock", {32'd0, d}, 64'd0);
    rd(8'h2C, d); chk("R1 dbg", {32'd0, d}, 64'd0);
    rd(8'h08, d); chk("R1 hi latch", {32'd0, d}, 64'd0);

    // R11 unmapped and write-only reads
    rd(8'h10, d); chk("R11 unmapped 10", {32'd0, d}, 64'd0);
    rd(8'h3C, d); chk("R11 unmapped 3C", {32'd0, d}, 64'd0);

    // R4 staged write (source 0, tick low: frozen)
    wr(8'h04, 32'hDEAD_BEEF);
    chk("R4 low staged only", time_o, 64'd0);
    wr(8'h00, 32'h0000_0001);
    chk("R4 full load", time_o, 64'h1_DEAD_BEEF);
    rd(8'h00, d); chk("R11 write-only 00", {32'd0, d}, 64'd0);
    rd(8'h04, d); chk("R11 write-only 04", {32'd0, d}, 64'd0);

    // R3 tick gating, several duty patterns
    for (int p = 0; p < 4; p++) begin
      a0 = time_o; highs = 0;
      for (int i = 0; i < 24; i++) begin
        tick_en = ((i % (p + 2)) == 0);
        if (tick_en) highs++;
        @(negedge clk);
      end
      tick_en = 1'b0;
      chk("R3 tick count", time_o, a0 + 64'(highs));
    end

    // R2 clock source
    wr(8'h38, 32'd1);
    rd(8'h38, d); chk("R11 source readback", {32'd0, d}, 64'd1);
    a0 = time_o; wait_n(7);
    chk("R2 every cycle", time_o, a0 + 64'd7);

    // R8 pause
    wr(8'h30, 32'd1);
    a0 = time_o; wait_n(8);
    chk("R8 paused hold", time_o, a0);
    rd(8'h30, d); chk("R11 pause readback", {32'd0, d}, 64'd1);
    wr(8'h30, 32'd0);
    a0 = time_o; wait_n(3);
    chk("R8 resume", time_o, a0 + 64'd3);

    // R9 debug gating sweep
    for (int en = 0; en < 4; en++) begin
      wr(8'h2C, 32'(en));
      rd(8'h2C, d); chk("R11 dbg readback", {32'd0, d}, 64'(en));
      for (int act = 0; act < 4; act++) begin
        dbg_act = 2'(act);
        a0 = time_o; wait_n(5);
        chk("R9 dbg gate", time_o, ((en & act) != 0) ? a0 : a0 + 64'd5);
        dbg_act = 2'b00;
      end
    end
    wr(8'h2C, 32'd0);

    // R5 load over increment while counting every cycle
    wr(8'h04, 32'h1234_5678);
    wr(8'h00, 32'hA5A5_0000);
    chk("R5 load wins", time_o, 64'hA5A5_0000_1234_5678);
    @(negedge clk);
    chk("R5 next step", time_o, 64'hA5A5_0000_1234_5679);

    // R6 / R7 coherent read across a carry
    wr(8'h04, 32'hFFFF_FFFD);
    wr(8'h00, 32'h0000_0007);
    rd(8'h0C, d); chk("R6 low read", {32'd0, d}, 64'h0000_0000_FFFF_FFFD);
    wait_n(6);
    rd(8'h08, d); chk("R6 latched high", {32'd0, d}, 64'd7);
    rd(8'h24, d); chk("R7 raw high live", {32'd0, d}, 64'd8);
    a0 = time_o;
    rd(8'h28, d); chk("R7 raw low live", {32'd0, d}, {32'd0, a0[31:0]});
    rd(8'h08, d); chk("R7 latch untouched", {32'd0, d}, 64'd7);

    // R10 lock
    wr(8'h34, 32'd0);
    rd(8'h34, d); chk("R10 zero write no lock", {32'd0, d}, 64'd0);
    wr(8'h34, 32'd1);
    rd(8'h34, d); chk("R10 lock set", {32'd0, d}, 64'd1);
    wr(8'h30, 32'd1);
    rd(8'h30, d); chk("R10 pause blocked", {32'd0, d}, 64'd0);
    a0 = time_o; wait_n(4);
    chk("R10 still counting", time_o, a0 + 64'd4);
    wr(8'h04, 32'd0);
    a0 = time_o;
    wr(8'h00, 32'd0);
    chk("R10 load blocked", time_o, a0 + 64'd1);
    wr(8'h38, 32'd0);
    rd(8'h38, d); chk("R10 source blocked", {32'd0, d}, 64'd1);
    wr(8'h34, 32'd0);
    rd(8'h34, d); chk("R10 lock sticky", {32'd0, d}, 64'd1);
    do_reset();
    rd(8'h34, d); chk("R10 reset clears lock", {32'd0, d}, 64'd0);
    chk("R1 time after reset", time_o, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule